// File: doc/BRIEF.md
# Black-Level Offset Servo

This block holds the digitized black level of one video channel at a programmed code. It does so by moving the code of a 10-bit offset DAC that sits ahead of the converter. The converter's samples enter on a data port. While a black-reference strobe is high, the block gathers the first 64 valid samples of the line and forms their mean. At the end of every N-th strobe it compares that mean with the black target, which is the programmed target plus a signed firmware trim, and moves the DAC code by exactly one step toward it. If the mean already lies within one code of the target, the DAC code stays where it is.

Because the code moves by at most one per N lines, the correction is far too slow to show as flicker. After four updates in a row with no step, the block raises a locked flag. Firmware can turn the servo off. The DAC code is then taken straight from a firmware-written register. When the servo is turned back on, it resumes from that value. A gain register shares the write port and feeds the gain path. Writes to it never touch the servo.

Top module: `black_level_servo`

## Requirements
- R1: Reset state: servo enabled, DAC code 512, locked low, gain code 512, target 64, trim 0, line interval 16.
- R2: The measurement is the sum of the first 64 samples taken on clock edges where blk_win and smp_valid are both high, divided by 64 (truncated). Further samples in the same window are ignored. If a window holds fewer than 64 samples, its update step makes no correction and leaves the lock run unchanged.
- R3: A window ends on the first clock edge at which blk_win is sampled low after being high. At an update step, the DAC code falls by exactly 1 if the mean exceeds target+1, and rises by exactly 1 if the mean is below target-1. The new code is visible after that edge.
- R4: At an update step where the mean is within ±1 code of the target, the DAC code is unchanged.
- R5: An update step occurs only at every N-th window end, where N is the line-interval register. A value of 0 behaves as 1. The line count restarts after each update step.
- R6: The servo DAC code saturates at 0 and 1023 and never wraps.
- R7: The target used is the clamp to 0..1023 of target + trim. The trim is a 7-bit two's-complement value (-64..+63) in converter LSB.
- R8: While the servo is disabled, dac_code equals the manual register. The servo code tracks that register, and the lock run, line count and accumulator are cleared. After re-enabling, the servo continues from the manual value.
- R9: A gain write changes gain_code only. It has no effect on dac_code, locked or servo state.
- R10: locked is high once 4 consecutive update steps have made no step request. Any step request clears it, including a request that is held at saturation. Disabling the servo also clears it, one cycle after the disable takes effect.
- R11: A write with reg_wr high takes effect at that clock edge. reg_sel selects the register: 0 = control (bit 0 is enable), 1 = target (10 bits), 2 = trim (bits 6:0), 3 = manual DAC code (10 bits), 4 = line interval (bits 7:0), 5 = gain (10 bits). Values 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 10 | Register write data |
| smp_valid | input | 1 | Converter sample valid |
| smp_data | input | 10 | Converter sample code |
| blk_win | input | 1 | Black-reference window strobe |
| dac_code | output | 10 | Offset DAC code |
| locked | output | 1 | Servo has settled |
| gain_code | output | 10 | Gain register value for the gain path |

## Verification
Most faults in this block's internal state show up as a wrong DAC code at a window end, not at once. A wrong accumulator sum or sample count stays hidden until the next update step. A wrong line count hides for up to N windows. A wrong lock-run count appears only on the fourth quiet update. The bench therefore compares a behavioural model against the ports on every clock. It also runs windows with mixed sample values, short windows and over-long windows, and it drives the code into both saturation limits, so that each stored quantity is forced to reach dac_code or locked within a window or two.

// File: rtl/bls_pkg.sv
package bls_pkg;
   typedef enum logic [2:0] {
      SEL_CTRL  = 3'd0,
      SEL_TGT   = 3'd1,
      SEL_TRIM  = 3'd2,
      SEL_MAN   = 3'd3,
      SEL_LINES = 3'd4,
      SEL_GAIN  = 3'd5
   } bls_sel_e;
endpackage

// File: rtl/bls_regs.sv
module bls_regs
   import bls_pkg::*;
#(
   parameter int DW          = 10,
   parameter int TRIM_W      = 7,
   parameter int LCNT_W      = 8,
   parameter int DEF_TARGET  = 64,
   parameter int DEF_MANUAL  = 512,
   parameter int DEF_LINES   = 16,
   parameter int DEF_GAIN    = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [2:0]        sel,
   input  logic [DW-1:0]     wdata,
   output logic              en,
   output logic [DW-1:0]     target,
   output logic [TRIM_W-1:0] trim,
   output logic [DW-1:0]     manual,
   output logic [LCNT_W-1:0] lines,
   output logic [DW-1:0]     gain
);
   generate
      if (TRIM_W > DW || LCNT_W > DW) begin : g_bad_width
         $error("bls_regs: field wider than write data");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en     <= 1'b1;
         target <= DW'(DEF_TARGET);
         trim   <= '0;
         manual <= DW'(DEF_MANUAL);
         lines  <= LCNT_W'(DEF_LINES);
         gain   <= DW'(DEF_GAIN);
      end else if (wr) begin
         case (bls_sel_e'(sel))
            SEL_CTRL:  en     <= wdata[0];
            SEL_TGT:   target <= wdata;
            SEL_TRIM:  trim   <= wdata[TRIM_W-1:0];
            SEL_MAN:   manual <= wdata;
            SEL_LINES: lines  <= wdata[LCNT_W-1:0];
            SEL_GAIN:  gain   <= wdata;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/bls_accum.sv
module bls_accum #(
   parameter int DW     = 10,
   parameter int AVG_LG = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          win,
   input  logic          valid,
   input  logic [DW-1:0] data,
   output logic          win_end,
   output logic          meas_ok,
   output logic [DW-1:0] avg
);
   localparam int SW = DW + AVG_LG;

   generate
      if (AVG_LG < 1 || AVG_LG > 10) begin : g_bad_avg
         $error("bls_accum: AVG_LG out of range");
      end
   endgenerate

   logic          blk_q;
   logic [AVG_LG:0] cnt;
   logic [SW-1:0] sum;
   logic          full;

   assign full    = cnt[AVG_LG];
   assign win_end = blk_q & ~win;
   assign meas_ok = full;
   assign avg     = sum[SW-1:AVG_LG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blk_q <= 1'b0;
         cnt   <= '0;
         sum   <= '0;
      end else begin
         blk_q <= win;
         if (clr || win_end) begin
            cnt <= '0;
            sum <= '0;
         end else if (win && valid && !full) begin
            sum <= sum + {{AVG_LG{1'b0}}, data};
            cnt <= cnt + {{AVG_LG{1'b0}}, 1'b1};
         end
      end
   end
endmodule

// File: rtl/bls_step.sv
module bls_step #(
   parameter int DW         = 10,
   parameter int TRIM_W     = 7,
   parameter int LCNT_W     = 8,
   parameter int LOCK_RUN   = 4,
   parameter int DEF_MANUAL = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              win_end,
   input  logic              meas_ok,
   input  logic [DW-1:0]     avg,
   input  logic [DW-1:0]     target,
   input  logic [TRIM_W-1:0] trim,
   input  logic [DW-1:0]     manual,
   input  logic [LCNT_W-1:0] lines,
   output logic [DW-1:0]     code,
   output logic              locked
);
   localparam int XW   = DW + 2;
   localparam int LK_W = $clog2(LOCK_RUN + 1);
   localparam logic signed [XW-1:0] ONE_X = XW'(1);
   localparam logic signed [XW-1:0] MAX_X = XW'((1 << DW) - 1);
   localparam logic [DW-1:0]        ONE_D = DW'(1);
   localparam logic [DW-1:0]        TOP_D = {DW{1'b1}};

   generate
      if (LOCK_RUN < 1) begin : g_bad_lock
         $error("bls_step: LOCK_RUN must be at least 1");
      end
   endgenerate

   logic signed [XW-1:0] raw_x, eff_x, avg_x;
   logic                 hi, lo, last;
   logic [LCNT_W:0]      lcnt_nx;
   logic [LCNT_W-1:0]    lcnt;
   logic [LK_W-1:0]      lk;

   always_comb begin
      raw_x = $signed({2'b00, target}) +
              $signed({{(XW-TRIM_W){trim[TRIM_W-1]}}, trim});
      if (raw_x < 0)          eff_x = '0;
      else if (raw_x > MAX_X) eff_x = MAX_X;
      else                    eff_x = raw_x;
      avg_x = $signed({2'b00, avg});
      hi    = avg_x > eff_x + ONE_X;
      lo    = avg_x < eff_x - ONE_X;
   end

   assign lcnt_nx = {1'b0, lcnt} + {{LCNT_W{1'b0}}, 1'b1};
   assign last    = lcnt_nx >= {1'b0, lines};
   assign locked  = (lk == LK_W'(LOCK_RUN));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code <= DW'(DEF_MANUAL);
         lcnt <= '0;
         lk   <= '0;
      end else if (!en) begin
         code <= manual;
         lcnt <= '0;
         lk   <= '0;
      end else if (win_end) begin
         if (!last) begin
            lcnt <= lcnt_nx[LCNT_W-1:0];
         end else begin
            lcnt <= '0;
            if (meas_ok) begin
               if (hi) begin
                  code <= (code == '0) ? code : code - ONE_D;
                  lk   <= '0;
               end else if (lo) begin
                  code <= (code == TOP_D) ? code : code + ONE_D;
                  lk   <= '0;
               end else if (!locked) begin
                  lk   <= lk + LK_W'(1);
               end
            end
         end
      end
   end
endmodule

// File: rtl/black_level_servo.sv
module black_level_servo #(
   parameter int DW         = 10,
   parameter int AVG_LG     = 6,
   parameter int TRIM_W     = 7,
   parameter int LCNT_W     = 8,
   parameter int LOCK_RUN   = 4,
   parameter int DEF_TARGET = 64,
   parameter int DEF_MANUAL = 512,
   parameter int DEF_LINES  = 16,
   parameter int DEF_GAIN   = 512
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [2:0]    reg_sel,
   input  logic [9:0]    reg_wdata,
   input  logic          smp_valid,
   input  logic [9:0]    smp_data,
   input  logic          blk_win,
   output logic [9:0]    dac_code,
   output logic          locked,
   output logic [9:0]    gain_code
);
   generate
      if (DW != 10) begin : g_bad_dw
         $error("black_level_servo: port widths assume DW of 10");
      end
   endgenerate

   logic              en_q;
   logic [DW-1:0]     tgt_q, man_q, srv_code, avg;
   logic [TRIM_W-1:0] trim_q;
   logic [LCNT_W-1:0] lines_q;
   logic              win_end, meas_ok;

   bls_regs #(
      .DW(DW), .TRIM_W(TRIM_W), .LCNT_W(LCNT_W),
      .DEF_TARGET(DEF_TARGET), .DEF_MANUAL(DEF_MANUAL),
      .DEF_LINES(DEF_LINES), .DEF_GAIN(DEF_GAIN)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
      .en(en_q), .target(tgt_q), .trim(trim_q), .manual(man_q),
      .lines(lines_q), .gain(gain_code)
   );

   bls_accum #(.DW(DW), .AVG_LG(AVG_LG)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(~en_q), .win(blk_win), .valid(smp_valid),
      .data(smp_data), .win_end(win_end), .meas_ok(meas_ok), .avg(avg)
   );

   bls_step #(
      .DW(DW), .TRIM_W(TRIM_W), .LCNT_W(LCNT_W),
      .LOCK_RUN(LOCK_RUN), .DEF_MANUAL(DEF_MANUAL)
   ) u_step (
      .clk(clk), .rst_n(rst_n), .en(en_q), .win_end(win_end), .meas_ok(meas_ok),
      .avg(avg), .target(tgt_q), .trim(trim_q), .manual(man_q), .lines(lines_q),
      .code(srv_code), .locked(locked)
   );

   assign dac_code = en_q ? srv_code : man_q;
endmodule

// File: rtl/bls_chk.sv
module bls_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       en,
   input logic       win_end,
   input logic       meas_ok,
   input logic       reg_wr,
   input logic [2:0] reg_sel,
   input logic [9:0] dac_code,
   input logic       locked
);
   // R3
   one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en)) |-> (dac_code == $past(dac_code) ||
                             dac_code == $past(dac_code) + 10'd1 ||
                             dac_code == $past(dac_code) - 10'd1));

   // R5
   step_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && dac_code != $past(dac_code)) |-> $past(win_end));

   // R2
   short_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && win_end && !meas_ok && !reg_wr) |=> $stable(dac_code));

   // R9
   gain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == 3'd5 && en && !win_end) |=> $stable(dac_code));

   // R10
   lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> ($past(win_end) && $past(en)));
endmodule

bind black_level_servo bls_chk u_chk (
   .clk(clk), .rst_n(rst_n), .en(en_q), .win_end(win_end), .meas_ok(meas_ok),
   .reg_wr(reg_wr), .reg_sel(reg_sel), .dac_code(dac_code), .locked(locked)
);

// File: tb/sim_black_level_servo.sv
`timescale 1ns/1ps
module sim_black_level_servo;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [2:0] reg_sel = '0;
   logic [9:0] reg_wdata = '0;
   logic       smp_valid = 1'b0;
   logic [9:0] smp_data = '0;
   logic       blk_win = 1'b0;
   logic [9:0] dac_code;
   logic       locked;
   logic [9:0] gain_code;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   black_level_servo u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .smp_valid(smp_valid), .smp_data(smp_data),
      .blk_win(blk_win), .dac_code(dac_code), .locked(locked),
      .gain_code(gain_code)
   );

   // behavioural reference model
   int m_en, m_tgt, m_trim, m_man, m_lines, m_gain;
   int m_blkq, m_cnt, m_sum, m_code, m_lcnt, m_lk;

   always @(posedge clk) begin : model
      int eff, nc, nl, nk, avg;
      bit wend;
      if (!rst_n) begin
         m_en = 1; m_tgt = 64; m_trim = 0; m_man = 512; m_lines = 16; m_gain = 512;
         m_blkq = 0; m_cnt = 0; m_sum = 0; m_code = 512; m_lcnt = 0; m_lk = 0;
      end else begin
         wend = (m_blkq != 0) && !blk_win;
         eff = m_tgt + m_trim;
         if (eff < 0) eff = 0;
         if (eff > 1023) eff = 1023;
         nc = m_code; nl = m_lcnt; nk = m_lk;
         if (m_en == 0) begin
            nc = m_man; nl = 0; nk = 0;
         end else if (wend) begin
            if (m_lcnt + 1 < m_lines) nl = m_lcnt + 1;
            else begin
               nl = 0;
               if (m_cnt == 64) begin
                  avg = m_sum / 64;
                  if (avg > eff + 1) begin nc = (m_code > 0) ? m_code - 1 : 0; nk = 0; end
                  else if (avg < eff - 1) begin nc = (m_code < 1023) ? m_code + 1 : 1023; nk = 0; end
                  else if (nk < 4) nk = nk + 1;
               end
            end
         end
         if (m_en == 0 || wend) begin m_sum = 0; m_cnt = 0; end
         else if (blk_win && smp_valid && m_cnt < 64) begin
            m_sum = m_sum + int'(smp_data); m_cnt = m_cnt + 1;
         end
         m_blkq = blk_win;
         m_code = nc; m_lcnt = nl; m_lk = nk;
         if (reg_wr) begin
            case (reg_sel)
               3'd0: m_en = int'(reg_wdata[0]);
               3'd1: m_tgt = int'(reg_wdata);
               3'd2: m_trim = reg_wdata[6] ? int'(reg_wdata[6:0]) - 128 : int'(reg_wdata[6:0]);
               3'd3: m_man = int'(reg_wdata);
               3'd4: m_lines = int'(reg_wdata[7:0]);
               3'd5: m_gain = int'(reg_wdata);
               default: ;
            endcase
         end
      end
   end

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks = checks + 3;
         if (int'(dac_code) != ((m_en != 0) ? m_code : m_man)) begin
            errors++;
            $display("FAIL model R3,R4,R5,R6,R7,R8 dac_code actual=%0d expected=%0d t=%0t",
                     dac_code, (m_en != 0) ? m_code : m_man, $time);
         end
         if (locked != (m_lk == 4)) begin
            errors++;
            $display("FAIL model R10 locked actual=%0d expected=%0d t=%0t", locked, m_lk == 4, $time);
         end
         if (int'(gain_code) != m_gain) begin
            errors++;
            $display("FAIL model R9,R11 gain_code actual=%0d expected=%0d t=%0t", gain_code, m_gain, $time);
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input int sel, input int val);
      reg_wr = 1'b1; reg_sel = 3'(sel); reg_wdata = 10'(val);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic line(input int v1, input int n1, input int v2, input int n2);
      for (int i = 0; i < n1; i++) begin
         blk_win = 1'b1; smp_valid = 1'b1; smp_data = 10'(v1);
         @(negedge clk);
      end
      for (int i = 0; i < n2; i++) begin
         blk_win = 1'b1; smp_valid = 1'b1; smp_data = 10'(v2);
         @(negedge clk);
      end
      blk_win = 1'b0; smp_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin : watchdog
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin : stim
      int p;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 dac_code", dac_code, 512);
      chk("R1 locked", locked, 0);
      chk("R1 gain_code", gain_code, 512);

      // R5 default interval 16: 15 windows no step, the 16th steps
      p = dac_code;
      for (int k = 0; k < 15; k++) line(300, 64, 0, 0);
      chk("R5 no step before 16th window", dac_code, p);
      line(300, 64, 0, 0);
      chk("R5 step on 16th window", dac_code, p - 1);

      wr(4, 1);                      // R11 interval register
      p = dac_code; line(100, 64, 0, 0);
      chk("R3 mean above target steps down", dac_code, p - 1);
      p = dac_code; line(10, 64, 0, 0);
      chk("R3 mean below target steps up", dac_code, p + 1);
      p = dac_code; line(65, 64, 0, 0);
      chk("R4 deadband upper edge", dac_code, p);
      p = dac_code; line(63, 64, 0, 0);
      chk("R4 deadband lower edge", dac_code, p);
      p = dac_code; line(0, 32, 128, 32);
      chk("R2 mixed samples mean 64", dac_code, p);
      p = dac_code; line(10, 64, 1000, 20);
      chk("R2 samples past 64 ignored", dac_code, p + 1);
      p = dac_code; line(1000, 63, 0, 0);
      chk("R2 short window no step", dac_code, p);

      // R10 lock after four quiet updates
      line(64, 64, 0, 0); line(64, 64, 0, 0); line(64, 64, 0, 0);
      chk("R10 not locked after three", locked, 0);
      line(64, 64, 0, 0);
      chk("R10 locked after four", locked, 1);
      line(1000, 63, 0, 0);
      chk("R10 short window keeps lock", locked, 1);
      line(200, 64, 0, 0);
      chk("R10 step clears lock", locked, 0);

      // R5 interval 3 and 0
      wr(4, 3);
      p = dac_code; line(200, 64, 0, 0); line(200, 64, 0, 0);
      chk("R5 interval 3 hold", dac_code, p);
      line(200, 64, 0, 0);
      chk("R5 interval 3 step", dac_code, p - 1);
      wr(4, 0);
      p = dac_code; line(200, 64, 0, 0);
      chk("R5 interval 0 acts as 1", dac_code, p - 1);

      // R7 trim
      wr(2, 20);
      p = dac_code; line(84, 64, 0, 0);
      chk("R7 trim +20 hold", dac_code, p);
      p = dac_code; line(80, 64, 0, 0);
      chk("R7 trim +20 step up", dac_code, p + 1);
      wr(1, 10); wr(2, 10'h040);
      p = dac_code; line(0, 64, 0, 0);
      chk("R7 clamp at zero hold", dac_code, p);
      p = dac_code; line(2, 64, 0, 0);
      chk("R7 clamp at zero step", dac_code, p - 1);
      wr(2, 0); wr(1, 64);

      // R9 gain write and R11 unused select
      p = dac_code;
      wr(5, 777);
      chk("R9 gain_code written", gain_code, 777);
      chk("R9 dac unchanged", dac_code, p);
      wr(7, 5);
      chk("R11 select 7 ignored dac", dac_code, p);
      chk("R11 select 7 ignored gain", gain_code, 777);

      // R8 bypass
      wr(0, 0); wr(3, 5);
      chk("R8 manual drives dac", dac_code, 5);
      line(1000, 64, 0, 0);
      chk("R8 servo frozen while disabled", dac_code, 5);
      chk("R8 locked low while disabled", locked, 0);

      // R6 saturation low
      wr(3, 1); wr(0, 1);
      chk("R8 resume from manual", dac_code, 1);
      line(500, 64, 0, 0);
      chk("R6 reach zero", dac_code, 0);
      line(500, 64, 0, 0);
      chk("R6 hold at zero", dac_code, 0);
      // R6 saturation high
      wr(0, 0); wr(3, 1022); wr(0, 1);
      line(0, 64, 0, 0);
      chk("R6 reach 1023", dac_code, 1023);
      line(0, 64, 0, 0);
      chk("R6 hold at 1023", dac_code, 1023);

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule